// File: doc/BRIEF.md
# Control/Bulk Service Ratio Arbiter

This block sits in a host controller's list scheduler. Each time the scheduler is ready to serve one non-periodic endpoint descriptor, it pulses a request. One cycle later the arbiter answers with a grant that names either the control list or the bulk list. The choice follows a programmable ratio. A 2-bit code allows one to four non-empty control descriptors to be served for every bulk descriptor. An internal tally counts the non-empty control descriptors that have completed. The tally is not cleared at frame boundaries, so the ratio holds across frames. When the list that the ratio prefers cannot be served, the arbiter falls back to the other list. When neither list can be served, it grants nothing.

The same block also gates periodic list processing. Software drives a periodic enable level. The arbiter samples that level only on the start-of-frame strobe, so a change made in the middle of a frame takes effect from the next frame.

Top module: `cbr_arbiter`

## Requirements
- R1: A ratio code k (0..3) gives k+1 control grants per bulk grant. This holds when both lists can be served and each control grant is followed by one non-empty completion. Encoding on `grant_bulk`: 0 means control, 1 means bulk.
- R2: A request is answered as follows. The arbiter prefers control while the tally is below k+1. It prefers bulk once the tally is at or above k+1.
- R3: The tally advances by one only on a completion strobe that reports a non-empty control descriptor. A completion that reports an empty descriptor leaves the tally unchanged.
- R4: A bulk grant chosen because the tally reached the quota clears the tally. If a non-empty completion arrives in the same cycle, the tally becomes 1.
- R5: When the preferred list cannot be served and the other one can, the other list is granted and the tally is left unchanged.
- R6: A request while neither list can be served produces no grant.
- R7: `grant_valid` is high exactly in the cycle after an accepted request, for one cycle only.
- R8: The start-of-frame strobe does not clear or alter the tally.
- R9: `per_active` takes the value of `per_list_en` in the cycle after a start-of-frame strobe. It ignores `per_list_en` at all other times.
- R10: After reset, the tally and the ratio code are 0 (1:1), and `grant_valid` and `per_active` are 0.
- R11: A ratio write is applied at the clock edge where it is presented. A request made in that same cycle is decided with the previous code.
- R12: The tally saturates at 4 and does not wrap under further non-empty completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_we | input | 1 | Load strobe for the ratio code |
| ratio_wdata | input | 2 | New ratio code (k gives k+1 control per bulk) |
| ctrl_ready | input | 1 | Control list is enabled and non-empty |
| bulk_ready | input | 1 | Bulk list is enabled and non-empty |
| sel_req | input | 1 | Request for the next non-periodic selection |
| svc_done | input | 1 | Completion strobe for a served control descriptor |
| svc_nonempty | input | 1 | With `svc_done`: the descriptor carried work |
| sof | input | 1 | Start-of-frame strobe |
| per_list_en | input | 1 | Software periodic list enable level |
| grant_valid | output | 1 | A selection is presented this cycle |
| grant_bulk | output | 1 | Selected list: 0 control, 1 bulk |
| per_active | output | 1 | Periodic processing permitted in this frame |

## Verification
Two pairs of functions can act on the same clock edge, and each pair is provoked on purpose.

The first pair is the quota-driven bulk grant and a non-empty completion. They are driven together at a tally at the quota. The next request must then be bulk again, because the tally restarts at 1 rather than 0.

The second pair is a ratio write and a request. They are driven in the same cycle, and the grant must follow the old code.

A behavioural model in the bench replays the same random streams, in which requests, completions, frame strobes and writes collide freely. The model is compared with the outputs on every clock.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

  typedef enum logic {
    LIST_CTRL = 1'b0,
    LIST_BULK = 1'b1
  } list_e;

  typedef struct packed {
    logic  valid;
    list_e pick;
    logic  by_quota;
  } choice_t;

  // Preferred list from the quota, fallback to the other when unservable.
  function automatic choice_t choose(input logic quota_met,
                                     input logic ctrl_ok,
                                     input logic bulk_ok);
    choice_t c;
    c = '0;
    if (quota_met) begin
      if (bulk_ok) begin
        c.valid = 1'b1; c.pick = LIST_BULK; c.by_quota = 1'b1;
      end else if (ctrl_ok) begin
        c.valid = 1'b1; c.pick = LIST_CTRL;
      end
    end else begin
      if (ctrl_ok) begin
        c.valid = 1'b1; c.pick = LIST_CTRL;
      end else if (bulk_ok) begin
        c.valid = 1'b1; c.pick = LIST_BULK;
      end
    end
    return c;
  endfunction

endpackage

// File: rtl/cbr_ratio_reg.sv
module cbr_ratio_reg #(
  parameter int RATIO_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [RATIO_W-1:0] wdata,
  output logic [RATIO_W-1:0] ratio
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ratio <= '0;
    else if (we) ratio <= wdata;
  end

  assert_ratio_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ratio == $past(wdata));

  assert_ratio_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(ratio));

endmodule

// File: rtl/cbr_ctrl_count.sv
module cbr_ctrl_count #(
  parameter int RATIO_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               inc,
  input  logic               clr,
  output logic               quota_met
);

  localparam int MAX_LIMIT = 2 ** RATIO_W;
  localparam int CNT_W     = $clog2(MAX_LIMIT + 1);

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] count_nx;

  function automatic logic [CNT_W-1:0] quota_of(input logic [RATIO_W-1:0] r);
    return CNT_W'(r) + CNT_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] base,
                                            input logic               up);
    if (up && (base != CNT_W'(MAX_LIMIT))) return base + CNT_W'(1);
    return base;
  endfunction

  assign quota_met = (count >= quota_of(ratio));

  always_comb count_nx = bump(clr ? '0 : count, inc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_nx;
  end

  assert_count_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(MAX_LIMIT));

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !inc |=> count == '0);

  assert_clear_inc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr && inc |=> count == CNT_W'(1));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !inc && !clr |=> $stable(count));

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    inc && !clr && (count < CNT_W'(MAX_LIMIT)) |=> count == $past(count) + CNT_W'(1));

endmodule

// File: rtl/cbr_pick.sv
module cbr_pick
  import cbr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sel_req,
  input  logic ctrl_ok,
  input  logic bulk_ok,
  input  logic quota_met,
  output logic quota_bulk,
  output logic grant_valid,
  output logic grant_bulk
);

  choice_t ch;
  logic    accept;

  always_comb ch = choose(quota_met, ctrl_ok, bulk_ok);

  assign accept     = sel_req && ch.valid;
  assign quota_bulk = accept && ch.by_quota;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_valid <= 1'b0;
      grant_bulk  <= 1'b0;
    end else begin
      grant_valid <= accept;
      grant_bulk  <= accept && (ch.pick == LIST_BULK);
    end
  end

  assert_grant_after_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> $past(sel_req));

  assert_no_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sel_req && !ctrl_ok && !bulk_ok |=> !grant_valid);

  assert_fallback_bulk_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sel_req && !ctrl_ok && bulk_ok |=> grant_valid && grant_bulk);

  assert_fallback_ctrl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sel_req && ctrl_ok && !bulk_ok |=> grant_valid && !grant_bulk);

  assert_quota_bulk_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_req && quota_met && bulk_ok |=> grant_bulk);

  assert_under_quota_ctrl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_req && !quota_met && ctrl_ok |=> grant_valid && !grant_bulk);

endmodule

// File: rtl/cbr_frame_gate.sv
module cbr_frame_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic sof,
  input  logic per_list_en,
  output logic per_active
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   per_active <= 1'b0;
    else if (sof) per_active <= per_list_en;
  end

  assert_latch_at_sof_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> per_active == $past(per_list_en));

  assert_hold_mid_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sof |=> $stable(per_active));

endmodule

// File: rtl/cbr_arbiter.sv
module cbr_arbiter #(
  parameter int RATIO_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ratio_we,
  input  logic [RATIO_W-1:0] ratio_wdata,
  input  logic               ctrl_ready,
  input  logic               bulk_ready,
  input  logic               sel_req,
  input  logic               svc_done,
  input  logic               svc_nonempty,
  input  logic               sof,
  input  logic               per_list_en,
  output logic               grant_valid,
  output logic               grant_bulk,
  output logic               per_active
);

  logic [RATIO_W-1:0] ratio;
  logic               tally_inc;   // named event: non-empty control completion
  logic               quota_bulk;  // named event: bulk granted on quota
  logic               quota_met;

  assign tally_inc = svc_done && svc_nonempty;

  cbr_ratio_reg #(.RATIO_W(RATIO_W)) u_ratio (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ratio_we),
    .wdata (ratio_wdata),
    .ratio (ratio)
  );

  cbr_ctrl_count #(.RATIO_W(RATIO_W)) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .ratio     (ratio),
    .inc       (tally_inc),
    .clr       (quota_bulk),
    .quota_met (quota_met)
  );

  cbr_pick u_pick (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel_req     (sel_req),
    .ctrl_ok     (ctrl_ready),
    .bulk_ok     (bulk_ready),
    .quota_met   (quota_met),
    .quota_bulk  (quota_bulk),
    .grant_valid (grant_valid),
    .grant_bulk  (grant_bulk)
  );

  cbr_frame_gate u_frame (
    .clk         (clk),
    .rst_n       (rst_n),
    .sof         (sof),
    .per_list_en (per_list_en),
    .per_active  (per_active)
  );

  // Frame start neither clears nor moves the quota decision.
  assert_sof_keeps_tally_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sof && !tally_inc && !quota_bulk && !ratio_we |=> $stable(quota_met));

  assert_grant_bulk_qual_R7: assert property (@(posedge clk) disable iff (!rst_n)
    grant_bulk |-> grant_valid);

endmodule

// File: tb/tb_cbr_arbiter.sv
`timescale 1ns/1ps
module tb_cbr_arbiter;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       ratio_we = 0, ctrl_ready = 1, bulk_ready = 1, sel_req = 0;
  logic       svc_done = 0, svc_nonempty = 0, sof = 0, per_list_en = 0;
  logic [1:0] ratio_wdata = '0;
  logic       grant_valid, grant_bulk, per_active;

  cbr_arbiter dut (
    .clk(clk), .rst_n(rst_n), .ratio_we(ratio_we), .ratio_wdata(ratio_wdata),
    .ctrl_ready(ctrl_ready), .bulk_ready(bulk_ready), .sel_req(sel_req),
    .svc_done(svc_done), .svc_nonempty(svc_nonempty), .sof(sof),
    .per_list_en(per_list_en), .grant_valid(grant_valid),
    .grant_bulk(grant_bulk), .per_active(per_active)
  );

  int    n_chk = 0, n_fail = 0;
  bit    finished = 0;
  string phase = "R10";

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference, updated on each rising edge.
  int m_cnt = 0, m_ratio = 0, m_per = 0, m_gv = 0, m_gb = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_ratio = 0; m_per = 0; m_gv = 0; m_gb = 0;
    end else begin
      int base;
      bit cleared;
      cleared = 0; m_gv = 0; m_gb = 0;
      if (sel_req) begin
        if (m_cnt >= m_ratio + 1) begin
          if (bulk_ready) begin m_gv = 1; m_gb = 1; cleared = 1; end
          else if (ctrl_ready) m_gv = 1;
        end else begin
          if (ctrl_ready) m_gv = 1;
          else if (bulk_ready) begin m_gv = 1; m_gb = 1; end
        end
      end
      base = cleared ? 0 : m_cnt;
      if (svc_done && svc_nonempty && base < 4) base++;
      m_cnt = base;
      if (ratio_we) m_ratio = ratio_wdata;
      if (sof) m_per = per_list_en;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check({phase, " model grant_valid"}, grant_valid, m_gv);
      check({phase, " model grant_bulk"}, grant_bulk, m_gb);
      check({phase, " model per_active"}, per_active, m_per);
    end
  end

  // One cycle of stimulus, then release all strobes.
  task automatic step(input bit req, input bit dn, input bit ne,
                      input bit we, input logic [1:0] wd, input bit sf);
    @(negedge clk);
    sel_req = req; svc_done = dn; svc_nonempty = ne;
    ratio_we = we; ratio_wdata = wd; sof = sf;
    @(negedge clk);
    sel_req = 0; svc_done = 0; svc_nonempty = 0; ratio_we = 0; sof = 0;
  endtask

  task automatic sel(input int exp_v, input int exp_b, input string tag);
    step(1, 0, 0, 0, 2'd0, 0);
    check({tag, " grant_valid"}, grant_valid, exp_v);
    if (exp_v != 0) check({tag, " grant_bulk"}, grant_bulk, exp_b);
  endtask

  task automatic done1(input bit ne);
    step(0, 1, ne, 0, 2'd0, 0);
  endtask

  task automatic wr(input logic [1:0] r);
    step(0, 0, 0, 1, r, 0);
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired (actual=hung expected=done)");
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 reset grant_valid", grant_valid, 0);
    check("R10 reset per_active", per_active, 0);
    sel(1, 0, "R10 default 1:1 first ctrl");
    done1(1);
    sel(1, 1, "R10 default 1:1 then bulk");

    phase = "R1";
    for (int r = 1; r <= 3; r++) begin
      wr(2'(r));
      for (int k = 0; k <= r; k++) begin
        sel(1, 0, "R1 ctrl within quota");
        done1(1);
      end
      sel(1, 1, "R1 bulk after quota");
    end

    phase = "R3";
    wr(2'd1);
    sel(1, 0, "R3 ctrl");
    done1(0); done1(0);
    sel(1, 0, "R3 empty completions ignored");
    done1(1); done1(1);
    sel(1, 1, "R2 bulk at quota");
    sel(1, 0, "R7 grant lasts one cycle follow-up");
    @(negedge clk);
    check("R7 no grant without request", grant_valid, 0);

    phase = "R12";
    wr(2'd3);
    for (int i = 0; i < 9; i++) done1(1);
    sel(1, 1, "R12 tally saturates, no wrap");

    phase = "R4";
    wr(2'd0);
    done1(1);
    step(1, 1, 1, 0, 2'd0, 0);
    check("R4 same-cycle bulk grant", grant_bulk, 1);
    sel(1, 1, "R4 tally restarted at 1");
    sel(1, 0, "R4 tally cleared to 0");

    phase = "R5";
    ctrl_ready = 0;
    sel(1, 1, "R5 fallback to bulk");
    ctrl_ready = 1;
    sel(1, 0, "R5 tally untouched by fallback");
    done1(1);
    bulk_ready = 0;
    sel(1, 0, "R5 fallback to ctrl");
    bulk_ready = 1;
    sel(1, 1, "R5 tally kept after ctrl fallback");

    phase = "R6";
    ctrl_ready = 0; bulk_ready = 0;
    sel(0, 0, "R6 nothing servable");
    ctrl_ready = 1; bulk_ready = 1;

    phase = "R8";
    wr(2'd1);
    done1(1);
    step(0, 0, 0, 0, 2'd0, 1);
    done1(1);
    step(0, 0, 0, 0, 2'd0, 1);
    sel(1, 1, "R8 tally kept across frames");

    phase = "R9";
    per_list_en = 1;
    repeat (2) @(negedge clk);
    check("R9 mid-frame enable ignored", per_active, 0);
    step(0, 0, 0, 0, 2'd0, 1);
    check("R9 enable taken at sof", per_active, 1);
    per_list_en = 0;
    repeat (2) @(negedge clk);
    check("R9 mid-frame disable ignored", per_active, 1);
    step(0, 0, 0, 0, 2'd0, 1);
    check("R9 disable taken at sof", per_active, 0);

    phase = "R11";
    wr(2'd3);
    done1(1);
    step(1, 0, 0, 1, 2'd0, 0);
    check("R11 same-cycle write uses old code", grant_bulk, 0);
    sel(1, 1, "R11 new code applies next");

    phase = "random R1 R2 R3 R4 R5 R6 R8 R9 R11 R12";
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      sel_req      = ($urandom % 2) == 0;
      svc_done     = ($urandom % 3) == 0;
      svc_nonempty = ($urandom % 4) != 0;
      ratio_we     = ($urandom % 40) == 0;
      ratio_wdata  = 2'($urandom);
      sof          = ($urandom % 25) == 0;
      per_list_en  = ($urandom % 2) == 0;
      ctrl_ready   = ($urandom % 5) != 0;
      bulk_ready   = ($urandom % 4) != 0;
    end
    @(negedge clk);
    sel_req = 0; svc_done = 0; ratio_we = 0; sof = 0;
    repeat (2) @(negedge clk);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule